// File: doc/BRIEF.md
# Hot-Spot Flow Control Scheduler

This block sits in front of a heavily loaded destination on an on-chip network and meters the traffic that sources may send to it. Sources do not push data blindly. Each one first sends a short request naming its own address, how many bytes it wants to send and how long the request may wait. The block throws out requests that are already stale and answers them with a refusal. It queues the rest in arrival order and then serves them one at a time. For each one it sends an allowance packet that names the source and the number of bytes it may now send.

No single allowance is larger than a fixed quota. When a request asks for more, it receives one quota's worth, and the rest of the request goes back to the tail of the queue. Long transfers therefore interleave with the requests waiting behind them, and a source never has to repeat a request. After each allowance the block waits for the source's acknowledgement before it serves anything else. It keeps accepting new requests during that wait.

Each request's wait limit becomes an absolute deadline on a free-running cycle counter when the request is accepted. A request that reaches the head of the queue after its deadline is refused with a NACK instead of being granted.

Top module: `hsfc_sched`

## Requirements
- R1: After reset, `tx_valid` is low and `req_ready` is high.
- R2: An accepted request whose controller address differs from `OWN_ADDR` is dropped silently. It causes no transmit and is never granted.
- R3: An accepted request for this controller whose timeout field is 0 or whose amount field is 0 is not queued. In the next cycle the block transmits a NACK carrying that source address and the requested amount.
- R4: The block serves queued requests in arrival order. An allowance carries the request's source address and an amount of min(remaining amount, `QUOTA`). An allowance amount is never 0.
- R5: At most one allowance is outstanding. After an allowance, nothing else is transmitted for queued requests until `ack` is pulsed.
- R6: When the granted amount is less than the remaining amount, the request is written back at the tail of the queue with its amount reduced by the grant. A request whose remainder is 0 is released on `ack` and not queued again.
- R7: A request that reaches the head of the queue at or after its deadline (the counter value at acceptance plus the timeout) receives a NACK carrying its remaining amount instead of an allowance.
- R8: An `ack` while no allowance is outstanding has no effect.
- R9: `req_ready` is low exactly when the queued requests plus any request currently held between grant and write-back fill all `DEPTH` slots. It is also low during the single write-back cycle.
- R10: `tx_kind` is 0 for an allowance and 1 for a NACK. `tx_src` and `tx_amount` are valid only while `tx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present on the receive port |
| req_ready | output | 1 | Block can take a request this cycle |
| req_hs_addr | input | ADDR_W | Controller address the request is sent to |
| req_src_addr | input | ADDR_W | Address of the requesting source |
| req_amount | input | AMT_W | Bytes requested |
| req_timeout | input | TMO_W | Cycles the request may wait |
| ack | input | 1 | Source has finished sending its granted amount |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_kind | output | 1 | 0 = allowance, 1 = NACK |
| tx_src | output | ADDR_W | Source the packet is sent to |
| tx_amount | output | AMT_W | Granted bytes, or the refused remaining amount |

## Verification
The assertions assume that a source pulses `ack` only after it has received an allowance. They also assume that a request never waits in the queue for half the counter range or longer, so that the wrap-safe deadline comparison stays correct. The stimulus sends `ack` only after it has observed an allowance, except in the deliberate spurious-ack case, which is issued while the block is idle. Every timeout it uses is far below half the counter range. Requests are presented only while `req_ready` is high, so every offered request is accepted.

// File: rtl/hsfc_pkg.sv
package hsfc_pkg;

  typedef enum logic {
    KIND_GRANT = 1'b0,
    KIND_NACK  = 1'b1
  } tx_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BACK = 2'd2
  } sched_st_e;

endpackage

// File: rtl/hsfc_timer.sv
module hsfc_timer #(
  parameter int TIME_W = 24,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic [TIME_W-1:0] deadline_i,
  output logic [TIME_W-1:0] deadline_new_o,
  output logic              past_due_o
);

  logic [TIME_W-1:0] now_q, now_d;
  logic [TIME_W-1:0] gap;

  always_comb begin
    now_d = now_q + TIME_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_d;
  end

  // Deadline for a request accepted in this cycle.
  assign deadline_new_o = now_q + TIME_W'(timeout_i);

  // Wrap-safe comparison: due once now has reached the deadline.
  assign gap        = now_q - deadline_i;
  assign past_due_o = ~gap[TIME_W-1];

endmodule

// File: rtl/hsfc_fifo.sv
module hsfc_fifo #(
  parameter int WIDTH = 48,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign do_wr = wr_en_i;
  assign do_rd = rd_en_i && (cnt_q != '0);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_wr) wp_d = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
    if (do_rd) rp_d = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + PTR_W'(1);
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = do_wr && (wp_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rp_q];
  assign empty_o   = (cnt_q == '0);
  assign count_o   = cnt_q;

endmodule

// File: rtl/hsfc_ctrl.sv
module hsfc_ctrl
  import hsfc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int AMT_W  = 16,
  parameter int TIME_W = 24,
  parameter int DEPTH  = 8,
  parameter int QUOTA  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_nack_i,
  input  logic [ADDR_W-1:0] arr_src_i,
  input  logic [AMT_W-1:0]  arr_amt_i,
  input  logic [ADDR_W-1:0] head_src_i,
  input  logic [AMT_W-1:0]  head_amt_i,
  input  logic [TIME_W-1:0] head_dl_i,
  input  logic              head_due_i,
  input  logic              empty_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              ack_i,
  output logic              pop_o,
  output logic              wb_push_o,
  output logic [ADDR_W-1:0] wb_src_o,
  output logic [AMT_W-1:0]  wb_amt_o,
  output logic [TIME_W-1:0] wb_dl_o,
  output logic              req_ready_o,
  output logic              tx_valid_o,
  output logic              tx_kind_o,
  output logic [ADDR_W-1:0] tx_src_o,
  output logic [AMT_W-1:0]  tx_amt_o
);

  localparam logic [AMT_W-1:0] QUOTA_C = AMT_W'(QUOTA);
  localparam logic [CNT_W:0]   SLOTS_C = (CNT_W + 1)'(DEPTH);

  sched_st_e         st_q, st_d;
  logic [ADDR_W-1:0] cur_src_q;
  logic [AMT_W-1:0]  cur_amt_q, cur_amt_d;
  logic [TIME_W-1:0] cur_dl_q;
  logic              cur_load;

  logic              txv_q, txv_d;
  tx_kind_e          txk_q, txk_d;
  logic [ADDR_W-1:0] txs_q, txs_d;
  logic [AMT_W-1:0]  txa_q, txa_d;

  logic [AMT_W-1:0]  grant_amt;
  logic [CNT_W:0]    occupied;
  logic              held;

  assign grant_amt = (head_amt_i > QUOTA_C) ? QUOTA_C : head_amt_i;

  always_comb begin
    st_d      = st_q;
    pop_o     = 1'b0;
    cur_load  = 1'b0;
    cur_amt_d = head_amt_i - grant_amt;
    txv_d     = 1'b0;
    txk_d     = txk_q;
    txs_d     = txs_q;
    txa_d     = txa_q;
    if (arr_nack_i) begin
      txv_d = 1'b1;
      txk_d = KIND_NACK;
      txs_d = arr_src_i;
      txa_d = arr_amt_i;
    end
    case (st_q)
      ST_IDLE: begin
        if (!empty_i && !arr_nack_i) begin
          pop_o = 1'b1;
          txv_d = 1'b1;
          txs_d = head_src_i;
          if (head_due_i) begin
            txk_d = KIND_NACK;
            txa_d = head_amt_i;
          end else begin
            txk_d    = KIND_GRANT;
            txa_d    = grant_amt;
            cur_load = 1'b1;
            st_d     = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (ack_i) st_d = (cur_amt_q != '0) ? ST_BACK : ST_IDLE;
      end
      ST_BACK: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      txv_q <= 1'b0;
      txk_q <= KIND_GRANT;
    end else begin
      st_q  <= st_d;
      txv_q <= txv_d;
      if (txv_d) txk_q <= txk_d;
    end
  end

  always_ff @(posedge clk) begin
    if (txv_d) begin
      txs_q <= txs_d;
      txa_q <= txa_d;
    end
    if (cur_load) begin
      cur_src_q <= head_src_i;
      cur_amt_q <= cur_amt_d;
      cur_dl_q  <= head_dl_i;
    end
  end

  assign held        = (st_q != ST_IDLE);
  assign occupied    = (CNT_W + 1)'(count_i) + (CNT_W + 1)'(held);
  assign req_ready_o = (st_q != ST_BACK) && (occupied < SLOTS_C);

  assign wb_push_o = (st_q == ST_BACK);
  assign wb_src_o  = cur_src_q;
  assign wb_amt_o  = cur_amt_q;
  assign wb_dl_o   = cur_dl_q;

  assign tx_valid_o = txv_q;
  assign tx_kind_o  = txk_q;
  assign tx_src_o   = txs_q;
  assign tx_amt_o   = txa_q;

endmodule

// File: rtl/hsfc_sched.sv
module hsfc_sched #(
  parameter int          ADDR_W   = 8,
  parameter int          AMT_W    = 16,
  parameter int          TMO_W    = 16,
  parameter int          TIME_W   = 24,
  parameter int          DEPTH    = 8,
  parameter int          QUOTA    = 64,
  parameter logic [7:0]  OWN_ADDR = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_hs_addr,
  input  logic [ADDR_W-1:0] req_src_addr,
  input  logic [AMT_W-1:0]  req_amount,
  input  logic [TMO_W-1:0]  req_timeout,
  input  logic              ack,
  output logic              tx_valid,
  output logic              tx_kind,
  output logic [ADDR_W-1:0] tx_src,
  output logic [AMT_W-1:0]  tx_amount
);

  localparam int ENT_W = ADDR_W + AMT_W + TIME_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [AMT_W-1:0]  amt;
    logic [TIME_W-1:0] dl;
  } entry_t;

  logic              accept, for_me, is_bad, arr_nack, arr_push;
  logic [TIME_W-1:0] dl_new;
  entry_t            wr_ent, head_ent;
  logic [ENT_W-1:0]  head_raw;
  logic              fifo_empty, head_due, pop, wb_push;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [ADDR_W-1:0] wb_src;
  logic [AMT_W-1:0]  wb_amt;
  logic [TIME_W-1:0] wb_dl;

  assign accept   = req_valid && req_ready;
  assign for_me   = (req_hs_addr == ADDR_W'(OWN_ADDR));
  assign is_bad   = (req_timeout == '0) || (req_amount == '0);
  assign arr_nack = accept && for_me && is_bad;
  assign arr_push = accept && for_me && !is_bad;

  always_comb begin
    if (wb_push) begin
      wr_ent.src = wb_src;
      wr_ent.amt = wb_amt;
      wr_ent.dl  = wb_dl;
    end else begin
      wr_ent.src = req_src_addr;
      wr_ent.amt = req_amount;
      wr_ent.dl  = dl_new;
    end
  end

  assign head_ent = entry_t'(head_raw);

  hsfc_timer #(.TIME_W(TIME_W), .TMO_W(TMO_W)) u_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .timeout_i      (req_timeout),
    .deadline_i     (head_ent.dl),
    .deadline_new_o (dl_new),
    .past_due_o     (head_due)
  );

  hsfc_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (arr_push || wb_push),
    .wr_data_i (wr_ent),
    .rd_en_i   (pop),
    .rd_data_o (head_raw),
    .empty_o   (fifo_empty),
    .count_o   (fifo_cnt)
  );

  hsfc_ctrl #(
    .ADDR_W (ADDR_W),
    .AMT_W  (AMT_W),
    .TIME_W (TIME_W),
    .DEPTH  (DEPTH),
    .QUOTA  (QUOTA)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .arr_nack_i  (arr_nack),
    .arr_src_i   (req_src_addr),
    .arr_amt_i   (req_amount),
    .head_src_i  (head_ent.src),
    .head_amt_i  (head_ent.amt),
    .head_dl_i   (head_ent.dl),
    .head_due_i  (head_due),
    .empty_i     (fifo_empty),
    .count_i     (fifo_cnt),
    .ack_i       (ack),
    .pop_o       (pop),
    .wb_push_o   (wb_push),
    .wb_src_o    (wb_src),
    .wb_amt_o    (wb_amt),
    .wb_dl_o     (wb_dl),
    .req_ready_o (req_ready),
    .tx_valid_o  (tx_valid),
    .tx_kind_o   (tx_kind),
    .tx_src_o    (tx_src),
    .tx_amt_o    (tx_amount)
  );

endmodule

// File: rtl/hsfc_sched_chk.sv
module hsfc_sched_chk #(
  parameter int         ADDR_W   = 8,
  parameter int         AMT_W    = 16,
  parameter int         TMO_W    = 16,
  parameter int         QUOTA    = 64,
  parameter logic [7:0] OWN_ADDR = 8'h5A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_hs_addr,
  input logic [ADDR_W-1:0] req_src_addr,
  input logic [AMT_W-1:0]  req_amount,
  input logic [TMO_W-1:0]  req_timeout,
  input logic              ack,
  input logic              tx_valid,
  input logic              tx_kind,
  input logic [ADDR_W-1:0] tx_src,
  input logic [AMT_W-1:0]  tx_amount
);

  logic granted_q;
  logic tx_grant;

  assign tx_grant = tx_valid && (tx_kind == 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        granted_q <= 1'b0;
    else if (tx_grant) granted_q <= 1'b1;
    else if (ack)      granted_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!tx_valid && req_ready); // R1
    end
  end

  AST_ARRIVAL_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_hs_addr == ADDR_W'(OWN_ADDR) &&
     (req_timeout == '0 || req_amount == '0))
    |=> (tx_valid && tx_kind == 1'b1 && tx_src == $past(req_src_addr))); // R3

  AST_QUOTA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> (tx_amount != '0 && tx_amount <= AMT_W'(QUOTA))); // R4

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> !granted_q); // R5

  AST_PULSE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> !tx_grant); // R5

endmodule

bind hsfc_sched hsfc_sched_chk #(
  .ADDR_W   (ADDR_W),
  .AMT_W    (AMT_W),
  .TMO_W    (TMO_W),
  .QUOTA    (QUOTA),
  .OWN_ADDR (OWN_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_hs_addr  (req_hs_addr),
  .req_src_addr (req_src_addr),
  .req_amount   (req_amount),
  .req_timeout  (req_timeout),
  .ack          (ack),
  .tx_valid     (tx_valid),
  .tx_kind      (tx_kind),
  .tx_src       (tx_src),
  .tx_amount    (tx_amount)
);

// File: tb/hsfc_sched_tb.sv
`timescale 1ns/1ps
module hsfc_sched_tb;

  localparam int         QUOTA = 64;
  localparam int         DEPTH = 8;
  localparam logic [7:0] OWN   = 8'h5A;

  logic        clk, rst_n;
  logic        req_valid, req_ready, ack;
  logic [7:0]  req_hs_addr, req_src_addr;
  logic [15:0] req_amount, req_timeout;
  logic        tx_valid, tx_kind;
  logic [7:0]  tx_src;
  logic [15:0] tx_amount;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct packed {
    logic        k;
    logic [7:0]  s;
    logic [15:0] a;
  } txrec_t;
  txrec_t tx_log[$];

  hsfc_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_hs_addr(req_hs_addr), .req_src_addr(req_src_addr),
    .req_amount(req_amount), .req_timeout(req_timeout),
    .ack(ack),
    .tx_valid(tx_valid), .tx_kind(tx_kind),
    .tx_src(tx_src), .tx_amount(tx_amount)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && tx_valid) tx_log.push_back({tx_kind, tx_src, tx_amount});
  end

  function automatic logic [15:0] chunk(input logic [15:0] rem);
    return (rem > 16'(QUOTA)) ? 16'(QUOTA) : rem;
  endfunction

  task automatic send_req(input logic [7:0] hs, input logic [7:0] src,
                          input logic [15:0] amt, input logic [15:0] tmo);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_hs_addr  = hs;
    req_src_addr = src;
    req_amount   = amt;
    req_timeout  = tmo;
    req_valid    = 1'b1;
    @(negedge clk);
    req_valid    = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic expect_tx(input logic k, input logic [7:0] s,
                           input logic [15:0] a, input string tag);
    int w;
    txrec_t r;
    w = 0;
    while (tx_log.size() == 0 && w < 300) begin
      @(negedge clk); #1;
      w++;
    end
    checks++;
    if (tx_log.size() == 0) begin
      fails++;
      $display("FAIL %s: nothing transmitted, expected kind=%0d src=%0h amt=%0d",
               tag, k, s, a);
    end else begin
      r = tx_log.pop_front();
      if (r.k !== k || r.s !== s || r.a !== a) begin
        fails++;
        $display("FAIL %s: got kind=%0d src=%0h amt=%0d, expected kind=%0d src=%0h amt=%0d",
                 tag, r.k, r.s, r.a, k, s, a);
      end
    end
  endtask

  task automatic expect_quiet(input int n, input string tag);
    txrec_t r;
    repeat (n) @(negedge clk);
    #1;
    checks++;
    if (tx_log.size() != 0) begin
      r = tx_log[0];
      fails++;
      $display("FAIL %s: got kind=%0d src=%0h amt=%0d, expected no transmit",
               tag, r.k, r.s, r.a);
      tx_log.delete();
    end
  endtask

  task automatic check_ready(input logic exp, input string tag);
    #1;
    checks++;
    if (req_ready !== exp) begin
      fails++;
      $display("FAIL %s: req_ready=%0d, expected %0d", tag, req_ready, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] rem, amt;
    logic [7:0]  src;
    int          sel;
    void'($urandom(32'h1ce5_0b17));
    rst_n = 1'b0; req_valid = 1'b0; ack = 1'b0;
    req_hs_addr = '0; req_src_addr = '0; req_amount = '0; req_timeout = '0;
    repeat (3) @(negedge clk);
    // R1: idle outputs while in reset and just after release
    checks++;
    if (tx_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: tx_valid=%0d req_ready=%0d, expected 0 1", tx_valid, req_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_ready(1'b1, "R1");

    // R2: foreign controller address is dropped
    send_req(8'h33, 8'h01, 16'd20, 16'd500);
    expect_quiet(8, "R2");

    // R3 / R10: zero timeout and zero amount refused at arrival
    send_req(OWN, 8'h02, 16'd40, 16'd0);
    expect_tx(1'b1, 8'h02, 16'd40, "R3 zero timeout");
    send_req(OWN, 8'h03, 16'd0, 16'd900);
    expect_tx(1'b1, 8'h03, 16'd0, "R3 zero amount");
    expect_quiet(5, "R3 not queued");

    // R4 / R10: plain grant below quota, no re-queue afterwards
    send_req(OWN, 8'h04, 16'd30, 16'd5000);
    expect_tx(1'b0, 8'h04, 16'd30, "R4 small grant");
    pulse_ack();
    expect_quiet(6, "R6 zero remainder released");

    // R5 / R6: split request interleaves with a later one
    send_req(OWN, 8'h0A, 16'd150, 16'd5000);
    expect_tx(1'b0, 8'h0A, 16'd64, "R4 quota grant");
    send_req(OWN, 8'h0B, 16'd10, 16'd5000);
    expect_quiet(10, "R5 wait for ack");
    pulse_ack();
    expect_tx(1'b0, 8'h0B, 16'd10, "R6 remainder behind newer request");
    pulse_ack();
    expect_tx(1'b0, 8'h0A, 16'd64, "R6 second chunk");
    pulse_ack();
    expect_tx(1'b0, 8'h0A, 16'd22, "R6 last chunk");
    pulse_ack();
    expect_quiet(6, "R6 done");

    // R7: expiry while queued and expiry of a written-back remainder
    send_req(OWN, 8'h0C, 16'd10, 16'd5000);
    expect_tx(1'b0, 8'h0C, 16'd10, "R4 grant C");
    send_req(OWN, 8'h0D, 16'd10, 16'd3);
    expect_quiet(20, "R5 hold");
    pulse_ack();
    expect_tx(1'b1, 8'h0D, 16'd10, "R7 expired in queue");
    expect_quiet(5, "R7 after nack");
    send_req(OWN, 8'h0E, 16'd100, 16'd40);
    expect_tx(1'b0, 8'h0E, 16'd64, "R4 grant E");
    expect_quiet(60, "R5 hold E");
    pulse_ack();
    expect_tx(1'b1, 8'h0E, 16'd36, "R7 remainder expired");
    expect_quiet(5, "R7 no grant");

    // R8: spurious ack while idle
    pulse_ack();
    expect_quiet(5, "R8 idle ack");
    send_req(OWN, 8'h0F, 16'd5, 16'd5000);
    expect_tx(1'b0, 8'h0F, 16'd5, "R8 normal after spurious ack");
    pulse_ack();
    expect_quiet(4, "R8 done");

    // R9: slot reservation and arrival order
    send_req(OWN, 8'h20, 16'd10, 16'd5000);
    expect_tx(1'b0, 8'h20, 16'd10, "R4 grant held");
    for (int i = 0; i < DEPTH - 1; i++) begin
      send_req(OWN, 8'(8'h10 + i), 16'(i + 1), 16'd5000);
      if (i == DEPTH - 3) check_ready(1'b1, "R9 one slot left");
    end
    check_ready(1'b0, "R9 full");
    for (int i = 0; i < DEPTH - 1; i++) begin
      pulse_ack();
      expect_tx(1'b0, 8'(8'h10 + i), 16'(i + 1), "R4 arrival order");
    end
    pulse_ack();
    expect_quiet(4, "R9 drained");
    check_ready(1'b1, "R9 ready again");

    // Constrained random: one request in flight at a time
    for (int it = 0; it < 40; it++) begin
      sel = int'($urandom % 8);
      src = 8'($urandom);
      amt = 16'(1 + ($urandom % 300));
      if (sel == 0) begin
        send_req(OWN ^ 8'(1 + ($urandom % 255)), src, amt, 16'd3000);
        expect_quiet(6, "R2 random foreign");
      end else if (sel == 1) begin
        send_req(OWN, src, amt, 16'd0);
        expect_tx(1'b1, src, amt, "R3 random refusal");
      end else begin
        send_req(OWN, src, amt, 16'(2000 + ($urandom % 2000)));
        rem = amt;
        while (rem != 0) begin
          expect_tx(1'b0, src, chunk(rem), "R6 random chunk");
          rem = rem - chunk(rem);
          pulse_ack();
        end
        expect_quiet(4, "R6 random release");
      end
    end

    finish_run();
  end

endmodule